// File: doc/BRIEF.md
# Tiled Surface Scanout Address Generator

This block produces the read addresses that a display fetch engine issues while it scans out a framebuffer held in an X-major tiled layout. A tile is 2048 bytes of memory. It covers 128 bytes horizontally and 16 scanlines vertically, and each of its 16 rows is one contiguous 128-byte slice. Tiles that sit side by side in the same tile row follow one another in memory at a 2048-byte stride. For every scanline the block walks across the surface from left to right and emits one 128-byte slice address per tile. It does not emit one long linear span.

The block is configured with a surface start address, the surface width counted in tiles, and the number of visible lines. Requests leave over a valid/ready handshake. Each request carries one flag that marks the last request of a scanline and another that marks the last request of the frame. Software may write a new start address at any time. That write is held in a pending register and reaches the address walk only at the next vertical-blank (frame start) pulse, so a frame never changes its start address partway through. Scrolling is done by moving the start address. The block has no finer pixel offset.

Top module: `tile_scan_gen`

## Requirements
- R1: After reset, reqValid stays low until a frameStart pulse arrives while widthTiles and lineCount are both non-zero.
- R2: The request for scanline y (0-based) and tile column x has address base + (y/16)*widthTiles*2048 + x*2048 + (y%16)*128. Here base is the start address latched at that frame's start.
- R3: Requests come in scanline order. Within a scanline they run x = 0 to widthTiles-1, and there are exactly widthTiles*lineCount requests per frame.
- R4: While reqValid is high and reqReady is low, reqValid stays high and reqAddr holds its value on the next cycle.
- R5: reqLastLine is high exactly on the request with x = widthTiles-1.
- R6: reqLastFrame is high only on the final request of the frame (x = widthTiles-1, y = lineCount-1), and never without reqLastLine.
- R7: A baseWe write takes effect at the next frameStart that begins a frame. A write during a frame, or in the same cycle as the accepted frameStart, does not change the frame in progress.
- R8: The cycle after the final request of a frame is accepted, reqValid is low. It stays low until the next frameStart.
- R9: A frameStart that arrives while a frame is in progress is ignored. A frameStart with widthTiles = 0 or lineCount = 0 produces no requests.
- R10: widthTiles and lineCount are sampled at the accepted frameStart. The in-tile line offset wraps from 15 to 0, and at that point the tile-row base advances by widthTiles*2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseIn | input | ADDR_W | New surface start address |
| baseWe | input | 1 | Write strobe for the pending start address |
| widthTiles | input | WIDTH_W | Surface width in tiles |
| lineCount | input | LINES_W | Visible scanlines per frame |
| frameStart | input | 1 | Vertical-blank pulse that begins a frame |
| reqReady | input | 1 | Consumer accepts the current request |
| reqValid | output | 1 | A fetch request is presented |
| reqAddr | output | ADDR_W | Byte address of the 128-byte slice |
| reqLastLine | output | 1 | Final request of the scanline |
| reqLastFrame | output | 1 | Final request of the frame |

## Verification
Some properties are checked by assertions on every cycle: a stalled request holds its address and its valid, the frame flag never appears without the line flag, valid drops after the last accept, and the tile-row base moves only on a frame start or on a line change. Other behaviour is shown only by the bench scenarios, which compare the full address stream against an arithmetic reference. These scenarios cover the walk order and the address values across a 16-line tile-row wrap, the deferred start address after a write during a frame, an ignored frame start during a frame, and frames with a zero width or a zero line count.

// File: rtl/tile_scan_pkg.sv
package tile_scan_pkg;
  typedef struct packed {
    logic load;
    logic nextTile;
    logic nextLine;
  } scanStb_t;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} scanState_t;
endpackage

// File: rtl/tile_scan_dp.sv
module tile_scan_dp
  import tile_scan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIDTH_W     = 8,
  parameter int LINES_W     = 12,
  parameter int TILE_BYTES  = 2048,
  parameter int SLICE_BYTES = 128,
  parameter int TILE_LINES  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  baseIn,
  input  logic               baseWe,
  input  logic [WIDTH_W-1:0] widthTiles,
  input  logic [LINES_W-1:0] lineCount,
  input  scanStb_t           stb,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               lastTile,
  output logic               lastLine,
  output logic               cfgOk
);
  localparam int TILE_SHIFT  = $clog2(TILE_BYTES);
  localparam int SLICE_SHIFT = $clog2(SLICE_BYTES);
  localparam int TL_W        = $clog2(TILE_LINES);

  logic [ADDR_W-1:0]  pendingBase;
  logic [ADDR_W-1:0]  rowBase;
  logic [WIDTH_W-1:0] tileX;
  logic [WIDTH_W-1:0] widthQ;
  logic [LINES_W-1:0] lineIdx;
  logic [LINES_W-1:0] linesQ;
  logic [TL_W-1:0]    lineInTile;
  logic [ADDR_W-1:0]  stride;
  logic [ADDR_W-1:0]  nextSlice;

  assign stride    = ADDR_W'(widthQ) << TILE_SHIFT;
  assign nextSlice = rowBase + ((ADDR_W'(lineInTile) + ADDR_W'(1)) << SLICE_SHIFT);
  assign lastTile  = (tileX == widthQ - WIDTH_W'(1));
  assign lastLine  = (lineIdx == linesQ - LINES_W'(1));
  assign cfgOk     = (widthTiles != '0) && (lineCount != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingBase <= '0;
      rowBase     <= '0;
      curAddr     <= '0;
      tileX       <= '0;
      widthQ      <= '0;
      lineIdx     <= '0;
      linesQ      <= '0;
      lineInTile  <= '0;
    end else begin
      if (baseWe) pendingBase <= baseIn;
      if (stb.load) begin
        rowBase    <= pendingBase;
        curAddr    <= pendingBase;
        tileX      <= '0;
        lineIdx    <= '0;
        lineInTile <= '0;
        widthQ     <= widthTiles;
        linesQ     <= lineCount;
      end else if (stb.nextLine) begin
        tileX   <= '0;
        lineIdx <= lineIdx + LINES_W'(1);
        if (lineInTile == TL_W'(TILE_LINES - 1)) begin
          lineInTile <= '0;
          rowBase    <= rowBase + stride;
          curAddr    <= rowBase + stride;
        end else begin
          lineInTile <= lineInTile + TL_W'(1);
          curAddr    <= nextSlice;
        end
      end else if (stb.nextTile) begin
        tileX   <= tileX + WIDTH_W'(1);
        curAddr <= curAddr + ADDR_W'(TILE_BYTES);
      end
    end
  end

  // R7
  row_base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.nextLine) |=> $stable(rowBase));

  // R10
  slice_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.nextTile && !stb.load) |=> (curAddr == $past(curAddr) + ADDR_W'(TILE_BYTES)));
endmodule

// File: rtl/tile_scan_ctrl.sv
module tile_scan_ctrl
  import tile_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     reqReady,
  input  logic     cfgOk,
  input  logic     lastTile,
  input  logic     lastLine,
  output scanStb_t stb,
  output logic     reqValid,
  output logic     reqLastLine,
  output logic     reqLastFrame
);
  scanState_t state;
  logic fire;

  assign reqValid     = (state == S_RUN);
  assign fire         = reqValid && reqReady;
  assign reqLastLine  = reqValid && lastTile;
  assign reqLastFrame = reqValid && lastTile && lastLine;

  always_comb begin
    stb          = '0;
    stb.load     = (state == S_IDLE) && frameStart && cfgOk;
    stb.nextTile = fire && !lastTile;
    stb.nextLine = fire && lastTile && !lastLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (stb.load) state <= S_RUN;
        S_RUN:  if (fire && lastTile && lastLine) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  frame_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqLastFrame |-> reqLastLine);

  // R8
  idle_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLastFrame) |=> !reqValid);

  // R9
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !stb.load);
endmodule

// File: rtl/tile_scan_gen.sv
module tile_scan_gen
  import tile_scan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIDTH_W     = 8,
  parameter int LINES_W     = 12,
  parameter int TILE_BYTES  = 2048,
  parameter int SLICE_BYTES = 128,
  parameter int TILE_LINES  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  baseIn,
  input  logic               baseWe,
  input  logic [WIDTH_W-1:0] widthTiles,
  input  logic [LINES_W-1:0] lineCount,
  input  logic               frameStart,
  input  logic               reqReady,
  output logic               reqValid,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqLastLine,
  output logic               reqLastFrame
);
  scanStb_t stb;
  logic lastTile, lastLine, cfgOk;

  tile_scan_ctrl u_ctrl (
    .clk, .rstN, .frameStart, .reqReady, .cfgOk, .lastTile, .lastLine,
    .stb, .reqValid, .reqLastLine, .reqLastFrame
  );

  tile_scan_dp #(
    .ADDR_W(ADDR_W), .WIDTH_W(WIDTH_W), .LINES_W(LINES_W),
    .TILE_BYTES(TILE_BYTES), .SLICE_BYTES(SLICE_BYTES), .TILE_LINES(TILE_LINES)
  ) u_dp (
    .clk, .rstN, .baseIn, .baseWe, .widthTiles, .lineCount, .stb,
    .curAddr(reqAddr), .lastTile, .lastLine, .cfgOk
  );

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr)));
endmodule

// File: tb/tile_scan_gen_tb.sv
module tile_scan_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] baseIn = 0;
  logic        baseWe = 0;
  logic [7:0]  widthTiles = 0;
  logic [11:0] lineCount = 0;
  logic        frameStart = 0;
  logic        reqReady = 0;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        reqLastLine;
  logic        reqLastFrame;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_scan_gen u_dut (
    .clk, .rstN, .baseIn, .baseWe, .widthTiles, .lineCount, .frameStart,
    .reqReady, .reqValid, .reqAddr, .reqLastLine, .reqLastFrame
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeBase(input logic [31:0] b);
    @(negedge clk); baseIn = b; baseWe = 1;
    @(negedge clk); baseWe = 0;
  endtask

  function automatic logic [31:0] refAddr(input logic [31:0] b, input int w, input int y, input int x);
    return b + 32'((y / 16) * w * 2048 + x * 2048 + (y % 16) * 128);
  endfunction

  task automatic runFrame(input logic [31:0] b, input int w, input int n, input int mode,
                          input logic midWrite, input logic [31:0] midBase, input logic midStart);
    int k = 0;
    int cyc = 0;
    logic held = 0;
    logic [31:0] heldAddr = 0;
    logic wrDone = 0;
    logic stDone = 0;
    logic r;
    @(negedge clk); frameStart = 1; widthTiles = 8'(w); lineCount = 12'(n);
    @(negedge clk); frameStart = 0;
    while (k < w * n) begin
      case (mode)
        0: r = 1;
        1: r = (cyc % 3) != 0;
        default: r = (cyc % 4) < 2;
      endcase
      reqReady = r; baseWe = 0; frameStart = 0;
      if (midWrite && !wrDone && k >= 1) begin baseIn = midBase; baseWe = 1; wrDone = 1; end
      if (midStart && !stDone && k >= 3) begin frameStart = 1; stDone = 1; end
      if (!reqValid) begin
        check(0, "R3 valid dropped mid-frame", 0, 1);
      end else begin
        if (held) check(reqAddr == heldAddr, "R4 stalled address held", reqAddr, heldAddr);
        if (r) begin
          int y = k / w;
          int x = k % w;
          logic [31:0] e = refAddr(b, w, y, x);
          check(reqAddr == e, "R2/R3/R10 address", reqAddr, e);
          check(reqLastLine == (x == w - 1), "R5 line flag", reqLastLine, x == w - 1);
          check(reqLastFrame == (k == w * n - 1), "R6 frame flag", reqLastFrame, k == w * n - 1);
          k++;
          held = 0;
        end else begin
          held = 1; heldAddr = reqAddr;
        end
      end
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        check(0, "R3 frame timed out", k, w * n);
        break;
      end
    end
    reqReady = 0; baseWe = 0; frameStart = 0;
    check(!reqValid, "R8 idle after last request", reqValid, 0);
    repeat (3) @(negedge clk);
    check(!reqValid, "R8 stays idle without frameStart", reqValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: idle after reset, no frameStart
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!reqValid, "R1 idle after reset", reqValid, 0);
    end
    // R1 with zero config: frameStart ignored
    widthTiles = 0; lineCount = 5;
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    repeat (2) @(negedge clk);
    check(!reqValid, "R9 zero width gives no request", reqValid, 0);
    widthTiles = 3; lineCount = 0;
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    repeat (2) @(negedge clk);
    check(!reqValid, "R9 zero lines gives no request", reqValid, 0);

    // Base 0, small frame, always ready
    runFrame(32'h0, 3, 4, 0, 0, 0, 0);
    // Crosses a tile-row boundary, stalling consumer
    writeBase(32'h0001_0000);
    runFrame(32'h0001_0000, 2, 20, 1, 0, 0, 0);
    // R7/R9: mid-frame write and mid-frame frameStart must not disturb this frame
    writeBase(32'h0002_0000);
    runFrame(32'h0002_0000, 4, 3, 2, 1, 32'h0004_0000, 1);
    // R7: the deferred write now applies; R10 wraps at line 16
    runFrame(32'h0004_0000, 5, 17, 2, 0, 0, 0);
    // Single-tile-wide surface, single line
    writeBase(32'h0000_0800);
    runFrame(32'h0000_0800, 1, 1, 0, 0, 0, 0);
    // Width and line count sampled at frame start (R10)
    writeBase(32'h0008_0000);
    runFrame(32'h0008_0000, 3, 33, 1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule